// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains a ring of transmit descriptors that software builds in a shared word-addressed memory. Each descriptor takes 16 bytes: a control/status word at offset 0, an options word at offset 4 and a spare word at offset 8 (hardware reads neither of these), and the buffer byte address at offset 12. Software programs a ring base, issues a soft reset to point the engine at that base, fills descriptors, sets their ownership bits and writes the poll register.

The engine then works through the ring. For every descriptor that hardware owns, it reads the buffer address, sends the frame bytes one at a time over a valid/ready byte stream and writes the control word back with ownership cleared. It then moves on to the next descriptor. The engine stops when it reaches a descriptor that software still owns, and waits there for the next poll.

The memory port has a fixed read latency of one cycle: the data for a read issued at one clock edge is on `mem_rdata` before the next edge.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset `tx_valid`, `irq_done`, `err_pulse` and `mem_req` are low, and the engine makes no memory access until the first poll.
- R2: A register write with `reg_sel` = 1 (poll, any data) makes the engine fetch the control word at its current descriptor pointer.
- R3: Control word bits: [13:0] byte count, 15 end of ring, 28 last segment, 29 first segment, 31 hardware owned. For an owned descriptor with both segment bits set, the engine streams exactly the byte-count bytes starting at the buffer address (word 3). The byte at address A is taken from bits [8*(A mod 4)+7 : 8*(A mod 4)] of its word, and the start address may be unaligned.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R5: After the last byte, the engine writes the control word back with bit 31 cleared and every other bit unchanged. One cycle later `irq_done` pulses for exactly one cycle.
- R6: A fetched control word with bit 31 clear stops the engine with no stream and no write. The engine waits for the next poll.
- R7: After a descriptor with bit 15 set, the next fetch is at the ring base. Otherwise the next fetch is 16 bytes further on.
- R8: An owned descriptor that lacks either segment bit is written back with bit 31 cleared. No byte is sent, `err_pulse` pulses for one cycle and `irq_done` stays low.
- R9: A register write with `reg_sel` = 0 loads the ring base, with its low four bits forced to zero. A write with `reg_sel` = 2 aborts any transfer and returns the descriptor pointer to that base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 ring base, 1 poll, 2 soft reset |
| reg_wdata | input | AW | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| irq_done | output | 1 | One-cycle pulse per sent descriptor |
| err_pulse | output | 1 | One-cycle pulse per rejected descriptor |

## Verification
Take the poll write to be registered at edge k. The control-word read goes out after edge k+1 and the buffer-address read after edge k+3. The first frame byte is valid after edge k+7. Each further byte needs one handshake edge, and a word boundary adds two cycles for the next read. `irq_done` or `err_pulse` is high during the cycle after the write-back edge. A behavioural model in the bench builds a byte queue from the descriptors it writes. At every falling edge the bench compares any accepted byte with the head of that queue, checks that a stalled byte is held, and counts the pulses. Ring state and pulse counts are compared only after a settling window of several hundred cycles, which is far longer than any frame in the test.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
    localparam int LEN_W        = 14;
    localparam int OWN_BIT      = 31;
    localparam int FIRST_BIT    = 29;
    localparam int LAST_BIT     = 28;
    localparam int EOR_BIT      = 15;
    localparam int DESC_BYTES   = 16;
    localparam int BUF_WORD_OFS = 12;

    localparam logic [1:0] SEL_BASE  = 2'd0;
    localparam logic [1:0] SEL_POLL  = 2'd1;
    localparam logic [1:0] SEL_RESET = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_CTL,
        ST_CAP_CTL,
        ST_RD_BUF,
        ST_CAP_BUF,
        ST_RD_DAT,
        ST_CAP_DAT,
        ST_SEND,
        ST_WBACK
    } tx_state_e;
endpackage

// File: rtl/tx_ring_ptr.sv
module tx_ring_ptr
    import tx_ring_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    input  logic          take_poll,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] cur_ptr,
    output logic          poll_pend,
    output logic          soft_rst
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] cur;
        logic          pend;
    } ptr_t;

    ptr_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        soft_rst = reg_we && (reg_sel == SEL_RESET);
        if (reg_we && reg_sel == SEL_BASE)
            s_d.base = {reg_wdata[AW-1:4], 4'b0000};
        if (take_poll)
            s_d.pend = 1'b0;
        if (reg_we && reg_sel == SEL_POLL)
            s_d.pend = 1'b1;
        if (advance)
            s_d.cur = wrap ? s_q.base : s_q.cur + AW'(DESC_BYTES);
        if (soft_rst) begin
            s_d.cur  = s_q.base;
            s_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_ptr   = s_q.cur;
    assign poll_pend = s_q.pend;

    p_ptr_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_ptr[3:0] == 4'b0000);
    p_soft_rst_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (cur_ptr == $past(s_q.base)));
endmodule

// File: rtl/tx_ring_lane.sv
module tx_ring_lane #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0]         word,
    input  logic [$clog2(LANES)-1:0]   sel,
    output logic [7:0]                 byte_out
);
    logic [7:0] lane [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = word[8*i +: 8];
    end

    assign byte_out = lane[sel];
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
    import tx_ring_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic [7:0]    tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic          irq_done,
    output logic          err_pulse
);
    localparam int LANES = 4;

    typedef struct packed {
        tx_state_e        state;
        logic [31:0]      ctl;
        logic [31:0]      word;
        logic [AW-1:0]    bptr;
        logic [LEN_W-1:0] rem;
        logic             bad;
        logic             irq;
        logic             err;
    } eng_t;

    eng_t s_d, s_q;

    logic          take_poll, advance, soft_rst, poll_pend;
    logic [AW-1:0] cur_ptr;

    tx_ring_ptr #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .take_poll (take_poll),
        .advance   (advance),
        .wrap      (s_q.ctl[EOR_BIT]),
        .cur_ptr   (cur_ptr),
        .poll_pend (poll_pend),
        .soft_rst  (soft_rst)
    );

    tx_ring_lane #(.LANES(LANES)) u_lane (
        .word     (s_q.word),
        .sel      (s_q.bptr[1:0]),
        .byte_out (tx_data)
    );

    always_comb begin
        s_d       = s_q;
        s_d.irq   = 1'b0;
        s_d.err   = 1'b0;
        take_poll = 1'b0;
        advance   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_ptr;
        mem_wdata = {1'b0, s_q.ctl[30:0]};
        tx_valid  = 1'b0;

        case (s_q.state)
            ST_IDLE: begin
                if (poll_pend) begin
                    take_poll = 1'b1;
                    s_d.state = ST_RD_CTL;
                end
            end
            ST_RD_CTL: begin
                mem_req   = 1'b1;
                s_d.state = ST_CAP_CTL;
            end
            ST_CAP_CTL: begin
                s_d.ctl = mem_rdata;
                s_d.bad = 1'b0;
                if (!mem_rdata[OWN_BIT]) begin
                    s_d.state = ST_IDLE;
                end else if (!(mem_rdata[FIRST_BIT] && mem_rdata[LAST_BIT])) begin
                    s_d.bad   = 1'b1;
                    s_d.state = ST_WBACK;
                end else if (mem_rdata[LEN_W-1:0] == '0) begin
                    s_d.state = ST_WBACK;
                end else begin
                    s_d.state = ST_RD_BUF;
                end
            end
            ST_RD_BUF: begin
                mem_req   = 1'b1;
                mem_addr  = cur_ptr + AW'(BUF_WORD_OFS);
                s_d.state = ST_CAP_BUF;
            end
            ST_CAP_BUF: begin
                s_d.bptr  = mem_rdata[AW-1:0];
                s_d.rem   = s_q.ctl[LEN_W-1:0];
                s_d.state = ST_RD_DAT;
            end
            ST_RD_DAT: begin
                mem_req   = 1'b1;
                mem_addr  = {s_q.bptr[AW-1:2], 2'b00};
                s_d.state = ST_CAP_DAT;
            end
            ST_CAP_DAT: begin
                s_d.word  = mem_rdata;
                s_d.state = ST_SEND;
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    s_d.rem  = s_q.rem - 1'b1;
                    s_d.bptr = s_q.bptr + 1'b1;
                    if (s_q.rem == LEN_W'(1))
                        s_d.state = ST_WBACK;
                    else if (s_q.bptr[1:0] == 2'd3)
                        s_d.state = ST_RD_DAT;
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                advance   = 1'b1;
                s_d.irq   = !s_q.bad;
                s_d.err   = s_q.bad;
                s_d.state = ST_RD_CTL;
            end
            default: s_d.state = ST_IDLE;
        endcase

        if (soft_rst) begin
            s_d.state = ST_IDLE;
            s_d.irq   = 1'b0;
            s_d.err   = 1'b0;
            advance   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_done  = s_q.irq;
    assign err_pulse = s_q.err;

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);
    p_done_after_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done || err_pulse) |-> $past(mem_we));
    p_wb_clears_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && !mem_wdata[OWN_BIT]));
    p_hold_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !soft_rst) |=> (tx_valid && $stable(tx_data)));
    p_err_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_done && err_pulse));
endmodule

// File: tb/tb_tx_ring_engine.sv
module tb_tx_ring_engine;
    localparam int AW = 16;
    localparam time CLK_PERIOD = 10ns;
    localparam int SETTLE = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic [7:0]    tx_data;
    logic          tx_valid, irq_done, err_pulse;
    logic          tx_ready = 1'b0;

    logic          h_we = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [31:0]   h_data = '0;
    logic [31:0]   mem [0:255];

    int checks = 0, errors = 0, n_irq = 0, n_err = 0, cyc = 0, req_seen = 0, rdy_cnt = 0;
    logic [7:0] expq[$];
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    logic prev_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_ring_engine #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .irq_done(irq_done), .err_pulse(err_pulse)
    );

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        else if (h_we)         mem[h_addr[9:2]]   <= h_data;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:2]];
    end

    always @(posedge clk) begin
        #1;
        rdy_cnt++;
        tx_ready = (rdy_cnt % 3) != 1;
    end

    function automatic logic [7:0] pat(int a);
        return 8'((a * 13 + 5) & 255);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_req) req_seen++;
            if (prev_stall) check(tx_valid && tx_data == prev_data, "R4 held byte", int'(tx_data), int'(prev_data));
            if (tx_valid && tx_ready) begin
                if (expq.size() == 0) check(1'b0, "R6/R8 unexpected byte", int'(tx_data), -1);
                else begin
                    logic [7:0] e;
                    e = expq.pop_front();
                    check(tx_data == e, "R3 stream byte", int'(tx_data), int'(e));
                end
            end
            if (irq_done) n_irq++;
            if (err_pulse) n_err++;
            if (prev_irq && irq_done) check(1'b0, "R5 pulse width", 1, 0);
            prev_irq   = irq_done;
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
        end
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic hwr(int a, logic [31:0] d);
        @(negedge clk);
        h_we = 1'b1; h_addr = AW'(a); h_data = d;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic rwr(logic [1:0] s, int d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = AW'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic desc(int a, logic [31:0] ctl, int buf_a);
        hwr(a, ctl);
        hwr(a + 4, 32'hFFFF_FFFF);
        hwr(a + 8, 32'hDEAD_BEEF);
        hwr(a + 12, 32'(buf_a));
    endtask

    task automatic expect_frame(int buf_a, int len);
        for (int k = 0; k < len; k++) expq.push_back(pat(buf_a + k));
    endtask

    task automatic poll_wait();
        rwr(2'd1, 32'h1234);
        repeat (SETTLE) @(negedge clk);
    endtask

    localparam logic [31:0] OWN = 32'h8000_0000, FS = 32'h2000_0000, LS = 32'h1000_0000, EOR = 32'h0000_8000;

    initial begin
        logic [31:0] c0, c1;
        repeat (3) @(negedge clk);
        check(!tx_valid && !irq_done && !err_pulse && !mem_req, "R1 reset outputs", int'({tx_valid, irq_done, err_pulse, mem_req}), 0);
        rst_n = 1'b1;
        for (int a = 'h100; a < 'h340; a += 4)
            hwr(a, {pat(a + 3), pat(a + 2), pat(a + 1), pat(a)});
        check(req_seen == 0, "R1 no access before poll", req_seen, 0);

        rwr(2'd0, 'h10F);
        rwr(2'd2, 0);
        c0 = OWN | FS | LS | 32'd7;
        c1 = OWN | FS | LS | EOR | 32'd5;
        desc('h100, c0, 'h201);
        desc('h110, c1, 'h240);
        expect_frame('h201, 7);
        expect_frame('h240, 5);
        poll_wait();
        check(expq.size() == 0, "R2 R3 frames sent from pointer", expq.size(), 0);
        check(n_irq == 2, "R5 done pulses", n_irq, 2);
        check(mem['h40] == (c0 & ~OWN), "R5 writeback word0", int'(mem['h40]), int'(c0 & ~OWN));
        check(mem['h44] == (c1 & ~OWN), "R7 writeback keeps end-of-ring", int'(mem['h44]), int'(c1 & ~OWN));
        check(n_err == 0, "R8 no error pulse", n_err, 0);

        c0 = OWN | FS | 32'd4;
        hwr('h100, c0);
        hwr('h10C, 'h260);
        poll_wait();
        check(n_err == 1, "R8 error pulse", n_err, 1);
        check(n_irq == 2, "R8 no done pulse", n_irq, 2);
        check(mem['h40] == (c0 & ~OWN), "R8 returned to software", int'(mem['h40]), int'(c0 & ~OWN));

        rwr(2'd0, 'h180);
        rwr(2'd2, 0);
        desc('h180, OWN | FS | LS | 32'd9, 'h2C3);
        hwr('h190, 32'h0);
        expect_frame('h2C3, 9);
        poll_wait();
        check(n_irq == 3 && expq.size() == 0, "R9 soft reset to base", n_irq, 3);
        poll_wait();
        check(n_irq == 3, "R6 not-owned stops", n_irq, 3);
        check(mem['h64] == 32'h0, "R6 no writeback", int'(mem['h64]), 0);

        desc('h190, OWN | FS | LS | EOR | 32'd3, 'h300);
        expect_frame('h300, 3);
        poll_wait();
        check(n_irq == 4 && expq.size() == 0, "R7 last entry sent", n_irq, 4);
        desc('h180, OWN | FS | LS | 32'd2, 'h310);
        expect_frame('h310, 2);
        poll_wait();
        check(n_irq == 5 && expq.size() == 0, "R7 wrap to base", n_irq, 5);
        check(n_err == 1, "R8 error count final", n_err, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule